// File: doc/BRIEF.md
# Pushbutton Power On/Off Sequencer

This block decides when a system's main power converter may run. A person turns the system on by holding a button for a debounce interval. A host can instead switch it on and off with a digital level. Turn-off from the button is a staged exchange with the host. A held press first raises an active-low interrupt. If the press goes on, a shutdown wait begins, and the host can stretch that wait as long as it needs by sending activity strobes. At the end of the wait the enable falls.

A kill input cuts power at once, but only after a blanking window that starts when the enable is released. Every interval is counted in ticks of an external 1 ms strobe, and all interval lengths are parameters. The block expects the pushbutton and the other level inputs to arrive already synchronized to `clk`.

Top module: `pbseq_power_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `seq_state` to 0 (off), `en_release` low and `int_n` high. The state codes are: 0 off, 1 turn-on debounce, 2 powered, 3 interrupt debounce, 4 interrupt held, 5 shutdown wait.
- R2: With `dig_mode` low, from the off state, holding `pb_n` low for BASE_MS+EXTRA_ON_MS ticks raises `en_release`. The enable then stays high while the block is powered.
- R3: Releasing `pb_n` during the turn-on debounce sends the block back to the off state on the next clock, and no output changes.
- R4: With `dig_mode` high, `pb_n` is ignored. A rising edge on `onoff` in the off state raises `en_release` one clock later.
- R5: After a pushbutton turn-on, a press that began before the turn-on does not count. `pb_n` must first return high before the next low can start the interrupt debounce.
- R6: While powered, with `dig_mode` low, a new press held for BASE_MS ticks drives `int_n` low (state 4). A release before that point returns the block to state 2.
- R7: If the press is held for EXTRA_OFF_MS more ticks after `int_n` falls, the block enters the shutdown wait. A release before that returns the block to state 2 and sets `int_n` high again.
- R8: In the shutdown wait, `int_n` stays low and `en_release` stays high for WAIT_MS ticks. The block then returns to off, with `en_release` low and `int_n` high.
- R9: An `ext_stb` pulse during the shutdown wait restarts the full WAIT_MS interval. There is no limit on how many restarts can occur.
- R10: While powered, `kill_n` low forces the block to off on the next clock. This applies only once BLANK_MS ticks have passed since the most recent turn-on; before that, `kill_n` is ignored.
- R11: With `dig_mode` high, a falling edge on `onoff` while in state 2 enters the shutdown wait.
- R12: Interval counts advance only on clocks where `tick_ms` is high. Without ticks, no debounce or wait ever completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_n | input | 1 | Synchronized pushbutton, low when pressed |
| dig_mode | input | 1 | High selects on/off control by `onoff` |
| onoff | input | 1 | Digital on/off level; its edges are commands |
| kill_n | input | 1 | Active-low forced power-off |
| ext_stb | input | 1 | One-clock host activity strobe |
| tick_ms | input | 1 | One-clock 1 ms timing strobe |
| en_release | output | 1 | High while the power converter may run |
| int_n | output | 1 | Active-low shutdown-imminent interrupt |
| seq_state | output | 3 | Current state code (see R1) |

## Verification
The bench builds the block with BASE_MS=3, EXTRA_ON_MS=2, EXTRA_OFF_MS=2, WAIT_MS=5 and BLANK_MS=8, and issues a tick every fourth clock. With these values every debounce, every restart of the shutdown wait and both sides of the kill blanking window fit within a few dozen clocks. The short intervals let the bench release presses just short of each boundary, and let it apply kill both inside and after the blanking window in one short run. A behavioural model compares all three outputs on every clock.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_ON_DEB   = 3'd1,
    ST_UP       = 3'd2,
    ST_INT_DEB  = 3'd3,
    ST_INT_HOLD = 3'd4,
    ST_SHUT     = 3'd5
  } seq_state_t;

  // Largest of three interval lengths, used to size the counters.
  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // States in which the converter is allowed to run.
  function automatic logic is_powered(seq_state_t s);
    return (s == ST_UP) || (s == ST_INT_DEB) || (s == ST_INT_HOLD) || (s == ST_SHUT);
  endfunction

  // States that hold the interrupt line asserted.
  function automatic logic irq_active(seq_state_t s);
    return (s == ST_INT_HOLD) || (s == ST_SHUT);
  endfunction

endpackage

// File: rtl/pbseq_interval.sv
module pbseq_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         done
);

  assign done = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pbseq_edge.sv
module pbseq_edge (
  input  logic clk,
  input  logic d,
  output logic rise,
  output logic fall
);

  logic prev_q;

  // The previous value is tracked through reset as well, so a level
  // already present at reset release is not seen as an edge.
  always_ff @(posedge clk) begin
    prev_q <= d;
  end

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;

endmodule

// File: rtl/pbseq_ctrl.sv
module pbseq_ctrl
  import pbseq_pkg::*;
#(
  parameter int W        = 8,
  parameter int ON_LIM   = 28,
  parameter int INT_LIM  = 26,
  parameter int OFF_LIM  = 0,
  parameter int WAIT_LIM = 400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pb_n,
  input  logic         dig_mode,
  input  logic         dig_rise,
  input  logic         dig_fall,
  input  logic         kill_n,
  input  logic         ext_stb,
  input  logic         phase_done,
  input  logic         blank_done,
  output seq_state_t   state,
  output logic         phase_clr,
  output logic [W-1:0] phase_limit,
  output logic         turn_on,
  output logic         kill_hit,
  output logic         wait_restart
);

  seq_state_t nxt;
  logic       armed_q;

  assign kill_hit = is_powered(state) && blank_done && !kill_n;

  always_comb begin
    nxt          = state;
    wait_restart = 1'b0;
    if (kill_hit) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (dig_mode) begin
            if (dig_rise) nxt = ST_UP;
          end else if (!pb_n) begin
            nxt = ST_ON_DEB;
          end
        end
        ST_ON_DEB: begin
          if (pb_n)            nxt = ST_OFF;
          else if (phase_done) nxt = ST_UP;
        end
        ST_UP: begin
          if (dig_mode) begin
            if (dig_fall) nxt = ST_SHUT;
          end else if (armed_q && !pb_n) begin
            nxt = ST_INT_DEB;
          end
        end
        ST_INT_DEB: begin
          if (pb_n)            nxt = ST_UP;
          else if (phase_done) nxt = ST_INT_HOLD;
        end
        ST_INT_HOLD: begin
          if (pb_n)            nxt = ST_UP;
          else if (phase_done) nxt = ST_SHUT;
        end
        ST_SHUT: begin
          if (ext_stb)         wait_restart = 1'b1;
          else if (phase_done) nxt = ST_OFF;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  assign turn_on   = (nxt == ST_UP) && ((state == ST_OFF) || (state == ST_ON_DEB));
  assign phase_clr = (nxt != state) || wait_restart;

  always_comb begin
    unique case (state)
      ST_ON_DEB:   phase_limit = W'(ON_LIM);
      ST_INT_DEB:  phase_limit = W'(INT_LIM);
      ST_INT_HOLD: phase_limit = W'(OFF_LIM);
      ST_SHUT:     phase_limit = W'(WAIT_LIM);
      default:     phase_limit = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      armed_q <= 1'b0;
    end else begin
      state <= nxt;
      if (turn_on)   armed_q <= 1'b0;
      else if (pb_n) armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pbseq_power_sequencer.sv
module pbseq_power_sequencer
  import pbseq_pkg::*;
#(
  parameter int BASE_MS      = 26,
  parameter int EXTRA_ON_MS  = 0,
  parameter int EXTRA_OFF_MS = 0,
  parameter int WAIT_MS      = 400,
  parameter int BLANK_MS     = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pb_n,
  input  logic       dig_mode,
  input  logic       onoff,
  input  logic       kill_n,
  input  logic       ext_stb,
  input  logic       tick_ms,
  output logic       en_release,
  output logic       int_n,
  output logic [2:0] seq_state
);

  localparam int ON_MS = BASE_MS + EXTRA_ON_MS;
  localparam int CW    = $clog2(max3(ON_MS, WAIT_MS, BLANK_MS) + 1) + 1;

  seq_state_t    state;
  logic          dig_rise, dig_fall;
  logic          phase_clr, phase_done, blank_done;
  logic          turn_on, kill_hit, wait_restart;
  logic [CW-1:0] phase_limit, phase_cnt, blank_cnt;

  pbseq_edge u_onoff_edge (
    .clk  (clk),
    .d    (onoff),
    .rise (dig_rise),
    .fall (dig_fall)
  );

  pbseq_interval #(.W(CW)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .clr   (phase_clr),
    .tick  (tick_ms),
    .limit (phase_limit),
    .cnt   (phase_cnt),
    .done  (phase_done)
  );

  pbseq_interval #(.W(CW)) u_blank (
    .clk   (clk),
    .rst   (rst),
    .clr   (turn_on),
    .tick  (tick_ms),
    .limit (CW'(BLANK_MS)),
    .cnt   (blank_cnt),
    .done  (blank_done)
  );

  pbseq_ctrl #(
    .W        (CW),
    .ON_LIM   (ON_MS),
    .INT_LIM  (BASE_MS),
    .OFF_LIM  (EXTRA_OFF_MS),
    .WAIT_LIM (WAIT_MS)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .pb_n         (pb_n),
    .dig_mode     (dig_mode),
    .dig_rise     (dig_rise),
    .dig_fall     (dig_fall),
    .kill_n       (kill_n),
    .ext_stb      (ext_stb),
    .phase_done   (phase_done),
    .blank_done   (blank_done),
    .state        (state),
    .phase_clr    (phase_clr),
    .phase_limit  (phase_limit),
    .turn_on      (turn_on),
    .kill_hit     (kill_hit),
    .wait_restart (wait_restart)
  );

  assign en_release = is_powered(state);
  assign int_n      = ~irq_active(state);
  assign seq_state  = state;

endmodule

// File: rtl/pbseq_checker.sv
module pbseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       pb_n,
  input logic       tick_ms,
  input logic       ext_stb,
  input logic       en_release,
  input logic       int_n,
  input logic [2:0] seq_state,
  input logic       phase_done,
  input logic       blank_done,
  input logic       dig_rise,
  input logic       kill_hit
);

  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> (seq_state == 3'd0 && !en_release && int_n)); // R1

  AST_ENABLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(en_release) |-> ($past(seq_state) == 3'd1 || $past(dig_rise))); // R2

  AST_DEB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd1 && pb_n) |=> (seq_state == 3'd0 && !en_release)); // R3

  AST_INT_POWERED: assert property (@(posedge clk) disable iff (rst)
    !int_n |-> en_release); // R8

  AST_EXTEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd5 && ext_stb && !kill_hit) |=> (seq_state == 3'd5)); // R9

  AST_KILL_BLANKED: assert property (@(posedge clk) disable iff (rst)
    (en_release && seq_state != 3'd5 && !blank_done) |=> en_release); // R10

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd1 && !pb_n && !tick_ms && !phase_done) |=> (seq_state == 3'd1)); // R12

endmodule

bind pbseq_power_sequencer pbseq_checker u_pbseq_checker (
  .clk        (clk),
  .rst        (rst),
  .pb_n       (pb_n),
  .tick_ms    (tick_ms),
  .ext_stb    (ext_stb),
  .en_release (en_release),
  .int_n      (int_n),
  .seq_state  (seq_state),
  .phase_done (phase_done),
  .blank_done (blank_done),
  .dig_rise   (dig_rise),
  .kill_hit   (kill_hit)
);

// File: tb/test_pbseq_power_sequencer.sv
module test_pbseq_power_sequencer;

  localparam int P_BASE  = 3;
  localparam int P_XON   = 2;
  localparam int P_XOFF  = 2;
  localparam int P_WAIT  = 5;
  localparam int P_BLANK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pb_n = 1'b1, dig_mode = 1'b0, onoff = 1'b0, kill_n = 1'b1, ext_stb = 1'b0, tick_ms = 1'b0;
  logic en_release, int_n;
  logic [2:0] seq_state;

  int errors = 0, checks = 0, cycles = 0, div = 0;
  logic tick_on = 1'b1;
  logic started = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_st = 0, m_cnt = 0, m_blank = 0;
  bit m_armed = 0, m_prev = 0;

  always #2.5 clk = ~clk;

  pbseq_power_sequencer #(
    .BASE_MS(P_BASE), .EXTRA_ON_MS(P_XON), .EXTRA_OFF_MS(P_XOFF),
    .WAIT_MS(P_WAIT), .BLANK_MS(P_BLANK)
  ) i_pbseq_power_sequencer (
    .clk(clk), .rst(rst), .pb_n(pb_n), .dig_mode(dig_mode), .onoff(onoff),
    .kill_n(kill_n), .ext_stb(ext_stb), .tick_ms(tick_ms),
    .en_release(en_release), .int_n(int_n), .seq_state(seq_state)
  );

  // Tick every fourth clock while enabled
  always @(negedge clk) begin
    div = (div + 1) % 4;
    tick_ms <= tick_on && (div == 0);
  end

  // Reference model: next outcome from the inputs seen at each edge
  always @(posedge clk) begin
    int lim, nst;
    bit rise, fall, powered, kill, restart, on_evt;
    cycles++;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_blank = 0; m_armed = 0; m_prev = onoff;
      started = 1'b1;
    end else begin
      rise = onoff && !m_prev;
      fall = !onoff && m_prev;
      m_prev = onoff;
      powered = (m_st >= 2);
      kill = powered && (m_blank >= P_BLANK) && !kill_n;
      case (m_st)
        1: lim = P_BASE + P_XON;
        3: lim = P_BASE;
        4: lim = P_XOFF;
        5: lim = P_WAIT;
        default: lim = 0;
      endcase
      nst = m_st; restart = 0;
      if (kill) nst = 0;
      else if (m_st == 0) begin
        if (dig_mode && rise) nst = 2;
        else if (!dig_mode && !pb_n) nst = 1;
      end else if (m_st == 1) begin
        if (pb_n) nst = 0; else if (m_cnt >= lim) nst = 2;
      end else if (m_st == 2) begin
        if (dig_mode && fall) nst = 5;
        else if (!dig_mode && m_armed && !pb_n) nst = 3;
      end else if (m_st == 3) begin
        if (pb_n) nst = 2; else if (m_cnt >= lim) nst = 4;
      end else if (m_st == 4) begin
        if (pb_n) nst = 2; else if (m_cnt >= lim) nst = 5;
      end else begin
        if (ext_stb) restart = 1; else if (m_cnt >= lim) nst = 0;
      end
      on_evt = (nst == 2) && (m_st <= 1);
      if (nst != m_st || restart) m_cnt = 0;
      else if (tick_ms && m_cnt < lim) m_cnt++;
      if (on_evt) m_blank = 0;
      else if (tick_ms && m_blank < P_BLANK) m_blank++;
      if (on_evt) m_armed = 0;
      else if (pb_n) m_armed = 1;
      m_st = nst;
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (seq_state !== 3'(m_st) || en_release !== (m_st >= 2) || int_n !== !(m_st >= 4)) begin
        errors++;
        $display("FAIL %s model: state=%0d en=%0b int_n=%0b expected state=%0d en=%0b int_n=%0b",
                 cur_req, seq_state, en_release, int_n, m_st, (m_st >= 2), !(m_st >= 4));
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_state(int s, int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (seq_state == 3'(s)) break;
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", seq_state, 0, "state after reset");
    chk("R1", en_release, 0, "enable after reset");
    chk("R1", int_n, 1, "irq after reset");

    cur_req = "R3";
    pb_n = 1'b0; step(10);
    chk("R3", seq_state, 1, "in turn-on debounce");
    pb_n = 1'b1; @(negedge clk);
    chk("R3", seq_state, 0, "short press discarded");
    chk("R3", en_release, 0, "enable unchanged");

    cur_req = "R2";
    pb_n = 1'b0; wait_state(2, 60);
    chk("R2", en_release, 1, "enable after full press");
    cur_req = "R5";
    step(60);
    chk("R5", int_n, 1, "held turn-on press raises no irq");
    chk("R5", seq_state, 2, "still powered");

    cur_req = "R6";
    pb_n = 1'b1; step(3);
    pb_n = 1'b0; step(5);
    chk("R6", seq_state, 3, "in irq debounce");
    pb_n = 1'b1; @(negedge clk);
    chk("R6", seq_state, 2, "short press back to powered");
    pb_n = 1'b0; wait_state(4, 40);
    chk("R6", int_n, 0, "irq after base hold");
    cur_req = "R7";
    pb_n = 1'b1; @(negedge clk);
    chk("R7", seq_state, 2, "release during off debounce");
    chk("R7", int_n, 1, "irq cleared");

    step(2);
    pb_n = 1'b0; wait_state(5, 80);
    chk("R7", seq_state, 5, "shutdown wait reached");
    pb_n = 1'b1;

    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin
      step(12);
      ext_stb = 1'b1; @(negedge clk); ext_stb = 1'b0;
      chk("R9", seq_state, 5, "wait extended");
    end
    cur_req = "R8";
    chk("R8", int_n, 0, "irq held in wait");
    wait_state(0, 60);
    chk("R8", en_release, 0, "enable low after wait");
    chk("R8", int_n, 1, "irq released after wait");

    cur_req = "R12";
    tick_on = 1'b0; pb_n = 1'b0; step(50);
    chk("R12", seq_state, 1, "no progress without ticks");
    tick_on = 1'b1;
    wait_state(2, 60);
    chk("R12", en_release, 1, "turn-on once ticks resume");

    cur_req = "R10";
    pb_n = 1'b1; kill_n = 1'b0; step(10);
    chk("R10", en_release, 1, "kill blanked after turn-on");
    wait_state(0, 60);
    chk("R10", en_release, 0, "kill after blanking");
    kill_n = 1'b1;

    cur_req = "R4";
    dig_mode = 1'b1; pb_n = 1'b0; step(40);
    chk("R4", seq_state, 0, "button ignored in digital mode");
    pb_n = 1'b1;
    onoff = 1'b1; @(negedge clk);
    chk("R4", en_release, 1, "digital rising edge turns on");
    cur_req = "R11";
    step(40);
    onoff = 1'b0; @(negedge clk);
    chk("R11", seq_state, 5, "digital falling edge starts shutdown");
    chk("R11", int_n, 0, "irq in digital shutdown");
    cur_req = "R8";
    wait_state(0, 60);
    chk("R8", en_release, 0, "digital shutdown completes");

    step(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule